// File: doc/BRIEF.md
# Data-Strobe Delay Window Calibrator

This block finds a working setting for a data-strobe delay line that sits outside it. It steps an 8-bit index upward from zero and drives the index out Gray-coded on `dly_code`. At each index it runs a short memory test through a request/response port. The test clears six words, writes six fixed 32-bit patterns and then reads them back. The first index at which all six words read back correctly is the low edge of the working window. The sweep then carries on from that same index, using a second test region, until a step fails. That failing index is the high edge. The block then applies the index two thirds of the way from the low edge to the high edge. If no index passes at all, it applies a fixed fallback code.

Words 0, 2 and 4 of a test go to the region base alone. Words 1, 3 and 5 also add `rank_base`, so the test reaches two ranks. The request port follows valid/ready rules. Once `req_valid` is raised, the request (`req_write`, `req_addr`, `req_wdata`) stays fixed until `req_ready` is seen high at a clock edge. At most one read is ever outstanding. Responses carry no ready signal: the block is always waiting when a read answer can arrive. A single-cycle `rsp_valid` pulse returns the read data. The controller pulses `start` once. It then waits for `done`, which stays high until the next `start`.

Top module: `dqs_window_cal`

## Requirements
- R1: While reset is held, and in the cycle after it, `busy`, `done` and `req_valid` are 0 and `dly_code` is 0x00.
- R2: One test step issues six writes of 0, then six writes of the patterns 0x12345678, 0x81234567, 0x78123456, 0x67812345, 0x56781234, 0x45678123 in that order, then reads the words back one at a time. Word k (0..5) is at region + k*0x100, and `rank_base` is added when k is odd.
- R3: The low-edge search uses region 0x4000. The high-edge search uses region 0x8000.
- R4: A read that returns data unequal to its pattern ends the step at once. A failing step therefore makes exactly 13 requests and a passing step makes 18.
- R5: During the step for index i, `dly_code` equals i XOR (i >> 1) and stays constant. The low search starts at index 0 and goes no higher than 0xFE. The high search starts at the low edge.
- R6: `low_bound` is the first passing index. `high_bound` is the first failing index at or above it, or 0xFF if every index up to 0xFE passes.
- R7: On completion, `dly_code` is the Gray code of low + ((high - low) * 2) / 3 (integer division). `done` rises with `busy` low, and `done` clears when the next run starts.
- R8: If no index passes, `dly_code` becomes 0x59, `used_default` is 1, and both bounds read 0.
- R9: While `req_valid` is high and `req_ready` is low, the request holds its value into the next cycle.
- R10: A `start` pulse while `busy` is high has no effect on the run in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a calibration run (pulse) |
| rank_base | input | ADDR_W | Offset added to odd test words |
| req_valid | output | 1 | Memory request valid |
| req_ready | input | 1 | Memory accepts the request |
| req_write | output | 1 | 1 = write, 0 = read |
| req_addr | output | ADDR_W | Request address |
| req_wdata | output | 32 | Write data |
| rsp_valid | input | 1 | Read data valid (one cycle) |
| rsp_data | input | 32 | Read data |
| dly_code | output | 8 | Gray-coded delay setting |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished; results valid |
| low_bound | output | 8 | First passing index |
| high_bound | output | 8 | First failing index above it |
| used_default | output | 1 | No index passed; fallback applied |

## Verification
If the step sequencer's word counter goes wrong, an address or pattern shows up at the request port that does not fit the rule for word k. This is visible within the same step. A sweep controller that advances at the wrong moment changes `dly_code` while requests are pending, or changes how many requests land in each region. Both are visible within one step. An error in the bound registers or in the two-thirds arithmetic appears only when `done` rises, as a wrong bound or a wrong final code. The bench therefore counts requests per region for each window and checks them against the window's own sweep count.

// File: rtl/dqs_cal_pkg.sv
package dqs_cal_pkg;

  localparam int NWORDS = 6;

  typedef enum logic [2:0] {
    W_IDLE, W_LOW_GO, W_LOW_WAIT, W_HIGH_GO, W_HIGH_WAIT, W_FINISH, W_DONE
  } win_state_t;

  typedef enum logic [2:0] {
    S_IDLE, S_CLR, S_WR, S_RD, S_WAIT
  } step_state_t;

  function automatic logic [31:0] pattern_word(input logic [2:0] k);
    case (k)
      3'd0:    return 32'h1234_5678;
      3'd1:    return 32'h8123_4567;
      3'd2:    return 32'h7812_3456;
      3'd3:    return 32'h6781_2345;
      3'd4:    return 32'h5678_1234;
      default: return 32'h4567_8123;
    endcase
  endfunction

endpackage

// File: rtl/dqs_pattern_gen.sv
module dqs_pattern_gen #(
  parameter int ADDR_W = 32,
  parameter int STRIDE = 32'h100
) (
  input  logic [ADDR_W-1:0] region_base,
  input  logic [ADDR_W-1:0] rank_base,
  input  logic [2:0]        word,
  output logic [ADDR_W-1:0] word_addr,
  output logic [31:0]       word_pat
);
  import dqs_cal_pkg::*;

  logic [ADDR_W-1:0] rank_part;

  always_comb begin
    rank_part = word[0] ? rank_base : '0;
    word_addr = region_base + (ADDR_W'(word) * ADDR_W'(STRIDE)) + rank_part;
    word_pat  = pattern_word(word);
  end
endmodule

// File: rtl/dqs_step_seq.sv
module dqs_step_seq #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [ADDR_W-1:0] word_addr,
  input  logic [31:0]       word_pat,
  output logic [2:0]        word,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_write,
  output logic [ADDR_W-1:0] req_addr,
  output logic [31:0]       req_wdata,
  input  logic              rsp_valid,
  input  logic [31:0]       rsp_data,
  output logic              step_done,
  output logic              step_pass
);
  import dqs_cal_pkg::*;

  localparam logic [2:0] LAST_WORD = 3'(NWORDS - 1);

  step_state_t st;
  logic        hs;

  always_comb begin
    req_valid = (st == S_CLR) || (st == S_WR) || (st == S_RD);
    req_write = (st != S_RD);
    req_addr  = word_addr;
    req_wdata = (st == S_WR) ? word_pat : 32'h0;
    hs        = req_valid && req_ready;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      word      <= '0;
      step_done <= 1'b0;
      step_pass <= 1'b0;
    end else begin
      step_done <= 1'b0;
      case (st)
        S_IDLE: if (go) begin
          st   <= S_CLR;
          word <= '0;
        end
        S_CLR: if (hs) begin
          if (word == LAST_WORD) begin
            word <= '0;
            st   <= S_WR;
          end else word <= word + 3'd1;
        end
        S_WR: if (hs) begin
          if (word == LAST_WORD) begin
            word <= '0;
            st   <= S_RD;
          end else word <= word + 3'd1;
        end
        S_RD: if (hs) st <= S_WAIT;
        S_WAIT: if (rsp_valid) begin
          if (rsp_data != word_pat) begin
            step_done <= 1'b1;
            step_pass <= 1'b0;
            st        <= S_IDLE;
          end else if (word == LAST_WORD) begin
            step_done <= 1'b1;
            step_pass <= 1'b1;
            st        <= S_IDLE;
          end else begin
            word <= word + 3'd1;
            st   <= S_RD;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dqs_window_ctrl.sv
module dqs_window_ctrl #(
  parameter int               IDX_W        = 8,
  parameter logic [IDX_W-1:0] LAST_IDX     = 8'hFE,
  parameter logic [IDX_W-1:0] DEFAULT_CODE = 8'h59
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             step_done,
  input  logic             step_pass,
  output logic             step_go,
  output logic             high_phase,
  output logic [IDX_W-1:0] dly_code,
  output logic             busy,
  output logic             done,
  output logic [IDX_W-1:0] low_bound,
  output logic [IDX_W-1:0] high_bound,
  output logic             used_default
);
  import dqs_cal_pkg::*;

  localparam int SW = IDX_W + 2;

  win_state_t       st;
  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] nxt_idx;
  logic [SW-1:0]    span;
  logic [SW-1:0]    ofs;
  logic [IDX_W-1:0] fin_idx;

  function automatic logic [IDX_W-1:0] to_gray(input logic [IDX_W-1:0] v);
    return v ^ (v >> 1);
  endfunction

  always_comb begin
    nxt_idx    = idx + 1'b1;
    span       = SW'(high_bound) - SW'(low_bound);
    ofs        = (span << 1) / SW'(3);
    fin_idx    = low_bound + ofs[IDX_W-1:0];
    step_go    = (st == W_LOW_GO) || (st == W_HIGH_GO);
    high_phase = (st == W_HIGH_GO) || (st == W_HIGH_WAIT);
    busy       = (st != W_IDLE) && (st != W_DONE);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st           <= W_IDLE;
      idx          <= '0;
      dly_code     <= '0;
      done         <= 1'b0;
      low_bound    <= '0;
      high_bound   <= '0;
      used_default <= 1'b0;
    end else begin
      case (st)
        W_IDLE, W_DONE: if (start) begin
          idx          <= '0;
          dly_code     <= '0;
          done         <= 1'b0;
          low_bound    <= '0;
          high_bound   <= '0;
          used_default <= 1'b0;
          st           <= W_LOW_GO;
        end
        W_LOW_GO:  st <= W_LOW_WAIT;
        W_HIGH_GO: st <= W_HIGH_WAIT;
        W_LOW_WAIT: if (step_done) begin
          if (step_pass) begin
            low_bound <= idx;
            st        <= W_HIGH_GO;
          end else if (idx == LAST_IDX) begin
            dly_code     <= DEFAULT_CODE;
            used_default <= 1'b1;
            done         <= 1'b1;
            st           <= W_DONE;
          end else begin
            idx      <= nxt_idx;
            dly_code <= to_gray(nxt_idx);
            st       <= W_LOW_GO;
          end
        end
        W_HIGH_WAIT: if (step_done) begin
          if (!step_pass) begin
            high_bound <= idx;
            st         <= W_FINISH;
          end else if (idx == LAST_IDX) begin
            high_bound <= nxt_idx;
            st         <= W_FINISH;
          end else begin
            idx      <= nxt_idx;
            dly_code <= to_gray(nxt_idx);
            st       <= W_HIGH_GO;
          end
        end
        W_FINISH: begin
          dly_code <= to_gray(fin_idx);
          done     <= 1'b1;
          st       <= W_DONE;
        end
        default: st <= W_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dqs_window_cal.sv
module dqs_window_cal #(
  parameter int ADDR_W      = 32,
  parameter int LOW_REGION  = 32'h4000,
  parameter int HIGH_REGION = 32'h8000,
  parameter int STRIDE      = 32'h100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] rank_base,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_write,
  output logic [ADDR_W-1:0] req_addr,
  output logic [31:0]       req_wdata,
  input  logic              rsp_valid,
  input  logic [31:0]       rsp_data,
  output logic [7:0]        dly_code,
  output logic              busy,
  output logic              done,
  output logic [7:0]        low_bound,
  output logic [7:0]        high_bound,
  output logic              used_default
);
  localparam int IDX_W = 8;

  logic              step_go, step_done, step_pass, high_phase;
  logic [ADDR_W-1:0] region_base, word_addr;
  logic [31:0]       word_pat;
  logic [2:0]        word;

  assign region_base = high_phase ? ADDR_W'(HIGH_REGION) : ADDR_W'(LOW_REGION);

  dqs_pattern_gen #(.ADDR_W(ADDR_W), .STRIDE(STRIDE)) u_pat (
    .region_base(region_base), .rank_base(rank_base), .word(word),
    .word_addr(word_addr), .word_pat(word_pat)
  );

  dqs_step_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .go(step_go),
    .word_addr(word_addr), .word_pat(word_pat), .word(word),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .step_done(step_done), .step_pass(step_pass)
  );

  dqs_window_ctrl #(.IDX_W(IDX_W), .LAST_IDX(8'hFE), .DEFAULT_CODE(8'h59)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .step_done(step_done), .step_pass(step_pass),
    .step_go(step_go), .high_phase(high_phase), .dly_code(dly_code),
    .busy(busy), .done(done), .low_bound(low_bound),
    .high_bound(high_bound), .used_default(used_default)
  );
endmodule

// File: rtl/dqs_window_cal_chk.sv
module dqs_window_cal_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [ADDR_W-1:0] rank_base,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [31:0]       req_wdata,
  input logic              rsp_valid,
  input logic [31:0]       rsp_data,
  input logic [7:0]        dly_code,
  input logic              busy,
  input logic              done,
  input logic [7:0]        low_bound,
  input logic [7:0]        high_bound,
  input logic              used_default
);
  a_r1_reset_idle: assert property (@(posedge clk)
    !rst_n |=> (!busy && !done && !req_valid && dly_code == 8'h00));

  a_r9_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=>
      (req_valid && $stable(req_addr) && $stable(req_wdata) && $stable(req_write)));

  a_r5_code_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && $past(req_valid)) |-> $stable(dly_code));

  a_r4_req_in_run: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> busy);

  a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r8_fallback: assert property (@(posedge clk) disable iff (!rst_n)
    (done && used_default) |-> (dly_code == 8'h59 && low_bound == 8'h00));

  a_r6_order: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !used_default) |-> (high_bound > low_bound));
endmodule

bind dqs_window_cal dqs_window_cal_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/dqs_window_cal_bench.sv
module dqs_window_cal_bench;

  typedef struct packed {
    logic [7:0]  wlo;
    logic [7:0]  whi;
    logic [7:0]  elow;
    logic [7:0]  ehigh;
    logic [7:0]  ecode;
    logic        edef;
    logic        midstart;
    logic [31:0] rank;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{8'h10, 8'h3F, 8'h10, 8'h40, 8'h28, 1'b0, 1'b0, 32'h0100_0000},
    '{8'h00, 8'h05, 8'h00, 8'h06, 8'h06, 1'b0, 1'b0, 32'h0200_0000},
    '{8'hF0, 8'hFF, 8'hF0, 8'hFF, 8'h87, 1'b0, 1'b0, 32'h0100_0000},
    '{8'h80, 8'h80, 8'h80, 8'h81, 8'hC0, 1'b0, 1'b0, 32'h0040_0000},
    '{8'h01, 8'h00, 8'h00, 8'h00, 8'h59, 1'b1, 1'b0, 32'h0100_0000},
    '{8'hFE, 8'hFE, 8'hFE, 8'hFF, 8'h81, 1'b0, 1'b0, 32'h0100_0000},
    '{8'h41, 8'h43, 8'h41, 8'h44, 8'h62, 1'b0, 1'b1, 32'h0080_0000}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] rank_base = 32'h0100_0000;
  logic        req_valid, req_write;
  logic        req_ready = 1'b0;
  logic [31:0] req_addr, req_wdata;
  logic        rsp_valid = 1'b0;
  logic [31:0] rsp_data = 32'h0;
  logic [7:0]  dly_code, low_bound, high_bound;
  logic        busy, done, used_default;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;

  logic [7:0]  win_lo = 8'h00, win_hi = 8'h00;
  int          low_hits, high_hits, bad_req;
  int          first_low_idx, last_low_idx, first_high_idx;
  logic [31:0] mem [logic [31:0]];

  always #5 clk = ~clk;

  dqs_window_cal u_dqs_window_cal (
    .clk(clk), .rst_n(rst_n), .start(start), .rank_base(rank_base),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .dly_code(dly_code), .busy(busy), .done(done),
    .low_bound(low_bound), .high_bound(high_bound), .used_default(used_default)
  );

  function automatic logic [31:0] pat(input int k);
    case (k)
      0: return 32'h1234_5678;
      1: return 32'h8123_4567;
      2: return 32'h7812_3456;
      3: return 32'h6781_2345;
      4: return 32'h5678_1234;
      default: return 32'h4567_8123;
    endcase
  endfunction

  function automatic logic [7:0] ungray(input logic [7:0] g);
    logic [7:0] b;
    b = g;
    b = b ^ (b >> 1);
    b = b ^ (b >> 2);
    b = b ^ (b >> 4);
    return b;
  endfunction

  // Returns word number, or -1; region 0 = low search, 1 = high search
  function automatic int word_of(input logic [31:0] a, input logic [31:0] base);
    for (int k = 0; k < 6; k++)
      if (a == base + 32'(k) * 32'h100 + ((k % 2 == 1) ? rank_base : 32'h0)) return k;
    return -1;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Memory model: ready pattern, one-cycle read latency, corrupt reads outside window
  initial begin
    logic        pend;
    logic [31:0] pdata;
    int          k;
    logic [7:0]  idx;
    pend = 1'b0;
    pdata = 32'h0;
    forever begin
      @(negedge clk);
      cyc++;
      rsp_valid = pend;
      rsp_data  = pdata;
      pend      = 1'b0;
      req_ready = (cyc % 3) != 2;
      if (rst_n && req_valid && req_ready) begin
        idx = ungray(dly_code);
        k = word_of(req_addr, 32'h4000);
        if (k >= 0) begin
          if (low_hits == 0) first_low_idx = int'(idx);
          last_low_idx = int'(idx);
          low_hits++;
        end else begin
          k = word_of(req_addr, 32'h8000);
          if (k >= 0) begin
            if (high_hits == 0) first_high_idx = int'(idx);
            high_hits++;
          end else bad_req++;
        end
        if (k >= 0) begin
          if (req_write) begin
            if (req_wdata != 32'h0 && req_wdata != pat(k)) bad_req++;
            mem[req_addr] = req_wdata;
          end else begin
            pend  = 1'b1;
            pdata = mem.exists(req_addr) ? mem[req_addr] : 32'h0;
            if (!(idx >= win_lo && idx <= win_hi)) pdata = pdata ^ 32'h1;
          end
        end
      end
    end
  end

  initial begin
    while (cyc < 190000) @(negedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected<190000", cyc);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  task automatic pulse_start();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_vec(input vec_t v, input int n);
    int exp_lo, exp_hi, lo;
    logic found;
    exp_lo = 0; exp_hi = 0; lo = 0; found = 1'b0;
    for (int i = 0; i <= 254 && !found; i++) begin
      if (i >= int'(v.wlo) && i <= int'(v.whi)) begin
        exp_lo += 18; found = 1'b1; lo = i;
      end else exp_lo += 13;
    end
    if (found) begin
      for (int j = lo; j <= 254; j++) begin
        if (j >= int'(v.wlo) && j <= int'(v.whi)) exp_hi += 18;
        else begin
          exp_hi += 13;
          break;
        end
      end
    end
    win_lo = v.wlo; win_hi = v.whi; rank_base = v.rank;
    low_hits = 0; high_hits = 0; bad_req = 0;
    first_low_idx = -1; last_low_idx = -1; first_high_idx = -1;
    mem.delete();
    pulse_start();
    check($sformatf("R7 done cleared on start v%0d", n), {31'b0, done}, 32'h0);
    check($sformatf("R7 busy after start v%0d", n), {31'b0, busy}, 32'h1);
    if (v.midstart) begin
      repeat (300) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    check($sformatf("R6 low bound v%0d", n), {24'b0, low_bound}, {24'b0, v.elow});
    check($sformatf("R6 high bound v%0d", n), {24'b0, high_bound}, {24'b0, v.ehigh});
    check($sformatf("R7 final code v%0d", n), {24'b0, dly_code}, {24'b0, v.ecode});
    check($sformatf("R8 default flag v%0d", n), {31'b0, used_default}, {31'b0, v.edef});
    check($sformatf("R3 R4 R9 low region requests v%0d", n), 32'(low_hits), 32'(exp_lo));
    check($sformatf("R3 R4 high region requests v%0d", n), 32'(high_hits), 32'(exp_hi));
    check($sformatf("R2 address and data shape v%0d", n), 32'(bad_req), 32'h0);
    check($sformatf("R5 sweep starts at 0 v%0d", n), 32'(first_low_idx), 32'h0);
    check($sformatf("R5 last low index v%0d", n), 32'(last_low_idx),
          v.edef ? 32'hFE : {24'b0, v.elow});
    if (!v.edef)
      check($sformatf("R5 high search starts at low v%0d", n), 32'(first_high_idx),
            {24'b0, v.elow});
    if (v.midstart)
      check($sformatf("R10 start while busy ignored v%0d", n), {24'b0, dly_code},
            {24'b0, v.ecode});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 busy in reset", {31'b0, busy}, 32'h0);
    check("R1 done in reset", {31'b0, done}, 32'h0);
    check("R1 req_valid in reset", {31'b0, req_valid}, 32'h0);
    check("R1 code in reset", {24'b0, dly_code}, 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 idle after reset", {30'b0, busy, done}, 32'h0);

    for (int n = 0; n < NV; n++) run_vec(VECS[n], n);

    // Reset during a run returns to the idle state
    win_lo = 8'h30; win_hi = 8'h60;
    pulse_start();
    repeat (200) @(negedge clk);
    check("R1 busy before mid-run reset", {31'b0, busy}, 32'h1);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R1 busy after mid-run reset", {31'b0, busy}, 32'h0);
    check("R1 req_valid after mid-run reset", {31'b0, req_valid}, 32'h0);
    check("R1 code after mid-run reset", {24'b0, dly_code}, 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    run_vec(VECS[0], 100);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule